// File: doc/BRIEF.md
# Debug session status tracker

This block follows the life of one on-chip debug session and presents it as a read-only 8-bit status word. A session opens when software writes the arm control bit to one. From then on the block records three things. It keeps the code of the state the sequencer is in. It keeps a sticky flag that rises once the trace buffer has taken 64 lines. It keeps a sticky flag that rises when an external tag hit arrives.

A session can end in two ways, and they leave the state code differently. When software clears the arm bit, the code keeps the last state reached, so a debugger can see how far the sequence got. When an internal trigger ends the session, the sequencer goes back to idle and the code reads zero. The block has two resets. Power-on reset clears everything. A system reset clears the session but leaves the buffer-full flag as it is, so that a trace captured before a watchdog or software reset can still be recognised as complete.

All pins are plain control and status pins. No data flows through the block, so no valid/ready handshake is used.

Top module: `dbg_session_status`

## Requirements
- R1: The state code takes only 000 (idle), 001 (state1), 010 (state2), 011 (state3) or 100 (final); a transition request whose target is 000 or 101..111 is ignored.
- R2: A cycle with `arm_wr` high sets the state code to 001, clears both flags and the internal line count, and takes priority over every other input in that cycle; the status reads 0x01 on the next cycle.
- R3: While armed, `seq_go` with a legal target loads that target into the state code on the next clock edge; while disarmed, `seq_go` has no effect.
- R4: A software disarm (`disarm_sw` while armed) ends the session and leaves the state code unchanged.
- R5: An internal trigger (`trig_end` while armed) ends the session and sets the state code to 000; it wins over a software disarm in the same cycle.
- R6: The buffer-full flag sets on the clock edge that takes the 64th `line_stored` pulse since arming, and stays set when the 7-bit line count wraps at 128.
- R7: The buffer-full flag is cleared only by an arm write or by power-on reset; a system reset, and an arm write made while system reset is held, leave it unchanged.
- R8: `ext_hit` while armed sets the tag flag; `ext_hit` while disarmed is ignored, and an arm write in the same cycle as a hit leaves the flag clear.
- R9: Status layout: bit 7 is the buffer-full flag, bit 6 the tag flag, bits 5:3 read 0 and bits 2:0 the state code; the block has no write path into the status word.
- R10: Power-on reset (`por_n` low) makes the status 0x00 at once; system reset (`sys_rst_n` low) at once clears the state code, the tag flag, the armed state and the line count.
- R11: `line_stored` pulses while disarmed are not counted toward the buffer-full threshold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| sys_rst_n | input | 1 | System reset, asynchronous, active low |
| arm_wr | input | 1 | Arm control bit written to one |
| disarm_sw | input | 1 | Software clears the arm bit |
| trig_end | input | 1 | Internal trigger ends the session |
| seq_go | input | 1 | Sequencer transition request |
| seq_target | input | 3 | Target state code for the transition |
| line_stored | input | 1 | One trace line was stored this cycle |
| ext_hit | input | 1 | External tag hit this cycle |
| stat_o | output | 8 | Read-only status word |

## Verification
The assertions check on every cycle that the state code never takes a reserved value, that the padding bits stay zero, and what follows from an arm write, a trigger end and a software disarm. They also check that the full flag stays set and that the tag flag does not move while disarmed or under system reset. Only the bench's scenarios can show the 64-line threshold, the fact that the flag stays set through a counter wrap, and that lines stored while disarmed are left out. The same holds for the split between the two resets and for the order of actions such as arm-with-hit and trigger-with-disarm.

// File: rtl/dbg_status_pkg.sv
package dbg_status_pkg;
  localparam int CODE_W = 3;
  localparam int STAT_W = 8;

  localparam logic [CODE_W-1:0] CODE_IDLE  = 3'b000;
  localparam logic [CODE_W-1:0] CODE_ONE   = 3'b001;
  localparam logic [CODE_W-1:0] CODE_FINAL = 3'b100;

  // field positions inside the status word
  localparam int POS_FULL = 7;
  localparam int POS_XHIT = 6;
endpackage

// File: rtl/dbg_seq_state.sv
// Armed state and state-sequencer code.
module dbg_seq_state
  import dbg_status_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              arm_wr,
  input  logic              disarm_sw,
  input  logic              trig_end,
  input  logic              seq_go,
  input  logic [CODE_W-1:0] seq_target,
  output logic              armed_o,
  output logic [CODE_W-1:0] code_o
);
  logic              armed_q;
  logic [CODE_W-1:0] code_q;
  logic              tgt_legal;

  // R1: only idle-excluded legal codes are accepted as targets
  assign tgt_legal = (seq_target != CODE_IDLE) && (seq_target <= CODE_FINAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      code_q  <= CODE_IDLE;
    end else if (arm_wr) begin
      armed_q <= 1'b1;
      code_q  <= CODE_ONE;
    end else if (armed_q) begin
      if (trig_end) begin
        armed_q <= 1'b0;
        code_q  <= CODE_IDLE;
      end else if (disarm_sw) begin
        armed_q <= 1'b0;
      end else if (seq_go && tgt_legal) begin
        code_q <= seq_target;
      end
    end
  end

  assign armed_o = armed_q;
  assign code_o  = code_q;
endmodule

// File: rtl/dbg_trace_track.sv
// Trace line counter and sticky buffer-full flag.
module dbg_trace_track #(
  parameter int CNT_W      = 7,
  parameter int FULL_LINES = 64
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_all_n,
  input  logic sys_rst_n,
  input  logic armed_i,
  input  logic arm_wr,
  input  logic line_stored,
  output logic full_o
);
  localparam logic [CNT_W-1:0] LAST_BEFORE_FULL = CNT_W'(FULL_LINES - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             full_q;
  logic             count_en;

  assign count_en = armed_i && line_stored && !arm_wr;

  // counter wraps naturally at 2**CNT_W
  always_ff @(posedge clk or negedge rst_all_n) begin
    if (!rst_all_n)    cnt_q <= '0;
    else if (arm_wr)   cnt_q <= '0;
    else if (count_en) cnt_q <= cnt_q + 1'b1;
  end

  // only power-on reset reaches this flop; system reset freezes it
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                                   full_q <= 1'b0;
    else if (!sys_rst_n)                          full_q <= full_q;
    else if (arm_wr)                              full_q <= 1'b0;
    else if (count_en && cnt_q == LAST_BEFORE_FULL) full_q <= 1'b1;
  end

  assign full_o = full_q;
endmodule

// File: rtl/dbg_tag_flag.sv
// Sticky external tag-hit flag.
module dbg_tag_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic armed_i,
  input  logic arm_wr,
  input  logic ext_hit,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag_q <= 1'b0;
    else if (arm_wr)            flag_q <= 1'b0;
    else if (armed_i && ext_hit) flag_q <= 1'b1;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dbg_session_status.sv
// Top: debug session status word.
module dbg_session_status
  import dbg_status_pkg::*;
#(
  parameter int CNT_W      = 7,
  parameter int FULL_LINES = 64
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              arm_wr,
  input  logic              disarm_sw,
  input  logic              trig_end,
  input  logic              seq_go,
  input  logic [CODE_W-1:0] seq_target,
  input  logic              line_stored,
  input  logic              ext_hit,
  output logic [STAT_W-1:0] stat_o
);
  logic              rst_all_n;
  logic              armed_w;
  logic [CODE_W-1:0] code_w;
  logic              full_w;
  logic              xhit_w;

  assign rst_all_n = por_n & sys_rst_n;

  dbg_seq_state u_seq (
    .clk        (clk),
    .rst_n      (rst_all_n),
    .arm_wr     (arm_wr),
    .disarm_sw  (disarm_sw),
    .trig_end   (trig_end),
    .seq_go     (seq_go),
    .seq_target (seq_target),
    .armed_o    (armed_w),
    .code_o     (code_w)
  );

  dbg_trace_track #(
    .CNT_W      (CNT_W),
    .FULL_LINES (FULL_LINES)
  ) u_trace (
    .clk         (clk),
    .por_n       (por_n),
    .rst_all_n   (rst_all_n),
    .sys_rst_n   (sys_rst_n),
    .armed_i     (armed_w),
    .arm_wr      (arm_wr),
    .line_stored (line_stored),
    .full_o      (full_w)
  );

  dbg_tag_flag u_tag (
    .clk     (clk),
    .rst_n   (rst_all_n),
    .armed_i (armed_w),
    .arm_wr  (arm_wr),
    .ext_hit (ext_hit),
    .flag_o  (xhit_w)
  );

  // R9: status word assembly
  always_comb begin
    stat_o                   = '0;
    stat_o[CODE_W-1:0]       = code_w;
    stat_o[POS_XHIT]         = xhit_w;
    stat_o[POS_FULL]         = full_w;
  end
endmodule

// File: rtl/dbg_session_status_chk.sv
module dbg_session_status_chk (
  input logic       clk,
  input logic       por_n,
  input logic       sys_rst_n,
  input logic       arm_wr,
  input logic       disarm_sw,
  input logic       trig_end,
  input logic       armed,
  input logic [7:0] stat
);
  p_code_legal_r1: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    stat[2:0] <= 3'd4);

  p_arm_enters_one_r2: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    arm_wr |=> (stat == 8'h01));

  p_disarm_keeps_r4: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (armed && disarm_sw && !trig_end && !arm_wr) |=> (stat[2:0] == $past(stat[2:0])));

  p_trig_idle_r5: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (armed && trig_end && !arm_wr) |=> (stat[2:0] == 3'b000));

  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (stat[7] && !arm_wr) |=> stat[7]);

  p_full_survives_sysrst_r7: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |=> $stable(stat[7]));

  p_tag_ignored_r8: assert property (@(posedge clk) disable iff (!por_n || !sys_rst_n)
    (!armed && !arm_wr) |=> $stable(stat[6]));

  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    stat[5:3] == 3'b000);
endmodule

bind dbg_session_status dbg_session_status_chk u_chk (
  .clk       (clk),
  .por_n     (por_n),
  .sys_rst_n (sys_rst_n),
  .arm_wr    (arm_wr),
  .disarm_sw (disarm_sw),
  .trig_end  (trig_end),
  .armed     (armed_w),
  .stat      (stat_o)
);

// File: tb/test_dbg_session_status.sv
module test_dbg_session_status;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NVEC       = 13;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, sys_rst_n = 1'b0;
  logic       arm_wr = 1'b0, disarm_sw = 1'b0, trig_end = 1'b0, seq_go = 1'b0;
  logic [2:0] seq_target = 3'b000;
  logic       line_stored = 1'b0, ext_hit = 1'b0;
  logic [7:0] stat_o;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbg_session_status i_dbg_session_status (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .arm_wr(arm_wr),
    .disarm_sw(disarm_sw), .trig_end(trig_end), .seq_go(seq_go),
    .seq_target(seq_target), .line_stored(line_stored), .ext_hit(ext_hit),
    .stat_o(stat_o)
  );

  // {arm, disarm, trig, go, target[2:0], line, hit, expected[7:0], req[3:0]}
  localparam logic [20:0] VEC [NVEC] = '{
    {4'b1000, 3'd0, 2'b00, 8'h01, 4'd2},  // R2 arm
    {4'b0001, 3'd2, 2'b00, 8'h02, 4'd3},  // R3 to state2
    {4'b0000, 3'd0, 2'b01, 8'h42, 4'd8},  // R8 hit armed
    {4'b0001, 3'd5, 2'b00, 8'h42, 4'd1},  // R1 reserved target ignored
    {4'b0001, 3'd3, 2'b00, 8'h43, 4'd3},  // R3 to state3
    {4'b0100, 3'd0, 2'b00, 8'h43, 4'd4},  // R4 software disarm keeps code
    {4'b0000, 3'd0, 2'b01, 8'h43, 4'd8},  // R8 hit while disarmed
    {4'b0001, 3'd4, 2'b00, 8'h43, 4'd3},  // R3 go while disarmed ignored
    {4'b1000, 3'd0, 2'b01, 8'h01, 4'd2},  // R2 arm beats hit
    {4'b0001, 3'd4, 2'b00, 8'h04, 4'd3},  // R3 to final
    {4'b0001, 3'd0, 2'b00, 8'h04, 4'd1},  // R1 target 000 ignored
    {4'b0110, 3'd0, 2'b00, 8'h00, 4'd5},  // R5 trigger beats disarm
    {4'b1000, 3'd0, 2'b00, 8'h01, 4'd2}   // R2 re-arm
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R%0d: stat=%02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step(input logic a, input logic d, input logic t, input logic g,
                      input logic [2:0] tg, input logic l, input logic h);
    @(negedge clk);
    arm_wr = a; disarm_sw = d; trig_end = t; seq_go = g;
    seq_target = tg; line_stored = l; ext_hit = h;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    @(negedge clk);
    arm_wr = 0; disarm_sw = 0; trig_end = 0; seq_go = 0;
    seq_target = 0; line_stored = 0; ext_hit = 0;
  endtask

  initial begin
    #3;
    check(10, stat_o, 8'h00);  // R10 reset state
    @(negedge clk); por_n = 1'b1; sys_rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][20], VEC[i][19], VEC[i][18], VEC[i][17], VEC[i][16:14],
           VEC[i][13], VEC[i][12]);
      check(int'(VEC[i][3:0]), stat_o, VEC[i][11:4]);
    end
    check(9, {5'b0, stat_o[5:3]}, 8'h00);  // R9 padding bits

    // R6: threshold at the 64th line, sticky through wrap
    step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 63; i++) step(0, 0, 0, 0, 0, 1, 0);
    check(6, stat_o, 8'h01);
    step(0, 0, 0, 0, 0, 1, 0);
    check(6, stat_o, 8'h81);
    for (int i = 0; i < 70; i++) step(0, 0, 0, 0, 0, 1, 0);
    check(6, stat_o, 8'h81);
    step(0, 0, 0, 0, 0, 0, 1);
    check(8, stat_o, 8'hC1);

    // R7 / R10: system reset keeps the full flag
    idle();
    sys_rst_n = 1'b0;
    #1 check(10, stat_o, 8'h80);
    step(1, 0, 0, 0, 0, 1, 1);
    check(7, stat_o, 8'h80);
    idle();
    sys_rst_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 0);
    check(7, stat_o, 8'h80);
    step(1, 0, 0, 0, 0, 0, 0);
    check(7, stat_o, 8'h01);

    // R11: lines while disarmed are not counted
    for (int i = 0; i < 60; i++) step(0, 0, 0, 0, 0, 1, 0);
    step(0, 1, 0, 0, 0, 0, 0);
    check(4, stat_o, 8'h01);
    for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 1, 0);
    check(11, stat_o, 8'h01);

    // R10: power-on reset clears the full flag too
    step(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 64; i++) step(0, 0, 0, 0, 0, 1, 0);
    check(6, stat_o, 8'h81);
    idle();
    por_n = 1'b0;
    #1 check(10, stat_o, 8'h00);
    @(negedge clk); por_n = 1'b1;
    step(0, 0, 0, 0, 0, 0, 1);
    check(8, stat_o, 8'h00);
    step(0, 0, 0, 1, 3'd2, 0, 0);
    check(3, stat_o, 8'h00);
    idle();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule